// File: doc/BRIEF.md
# Parallel Link Character Transmitter

This block is the sending half of a clock-synchronous, parallel, point-to-point on-chip link. Each clock it puts one character on a wide output bus with a valid strobe. The character is a flow-control token, a user data byte, an end-of-packet or error-end marker, or half of a NULL filler. Host words come in through a one-word holding register with a full flag. The host word's top bit tells a data byte apart from a packet marker.

The block keeps two counters. One is the credit granted by the far end. It grows by eight for every token received and falls by one for every data or marker character sent. The other is the room this end has already offered to the far end. The block sends a token only when the local receive buffer can take eight characters beyond what it has already granted. When it has nothing else to send, it sends NULL fillers without a break, so the far end always sees traffic. An odd parity bit runs across each pair of adjacent characters. The link state comes from an external link controller. The receiver is outside this block.

Top module: `link_char_tx`

## Requirements
- R1: `tx_char` is laid out as bit DATA_W+1 = parity, bit DATA_W = flag (0 data, 1 control), bits DATA_W-1:0 = payload. A data character carries the host byte as its payload. A control character carries its code in bits 1:0 (token=0, end-of-packet=1, error-end=2, escape=3), and the upper payload bits are 0.
- R2: A host word with top bit 0 is sent as a data character. A host word with top bit 1 is sent as error-end when bit 0 is 1, and as end-of-packet otherwise.
- R3: The parity bit is odd over three things: itself, the current flag, and the payload bits of the previous valid character. When the previous cycle carried no valid character, that previous payload counts as zero.
- R4: `link_state` is encoded as 0 error-reset, 1 error-wait, 2 ready, 3 started, 4 connecting, 5 run. `tx_valid` is 1 exactly when the state two clock edges earlier was 3, 4 or 5. While `tx_valid` is 0, `tx_char` shows the idle pattern: parity 1 and all other bits 0.
- R5: Each cycle the block chooses what to send in this order: the second half of a NULL already started, then a token, then a pending host word, then a new NULL.
- R6: A NULL is an escape character followed in the very next cycle by a token-code character. The second half does not count as a granted token.
- R7: A data or marker character is sent only in state 5 while credit is above zero. It spends one credit. Each `fct_rcvd` pulse adds 8 credits.
- R8: `credit_full` is 1 while credit exceeds 48. A `fct_rcvd` pulse arriving while `credit_full` is 1 is ignored. Credit returns to 0 in states 0, 1 and 2.
- R9: A token is sent only in states 4 or 5, and only when the granted count plus 8 is at most both `rx_free` and 56. Each token sent adds 8 to the granted count. Each `rx_nchar` pulse removes 1 from it, down to 0. The granted count returns to 0 in states 0, 1 and 2.
- R10: `host_full` is 1 from the edge after a write is accepted until the edge at which that word is chosen for sending. A write while `host_full` is 1 is ignored. A pending word survives a link drop.
- R11: After reset, `tx_valid`, `host_full` and `credit_full` are 0, and `tx_char` shows the idle pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| link_state | input | 3 | Link controller state (encoding in R4) |
| host_wr | input | 1 | Host write strobe |
| host_word | input | DATA_W+1 | Host word; top bit is the data/control flag |
| host_full | output | 1 | Holding register occupied |
| fct_rcvd | input | 1 | One-cycle pulse: a token arrived from the far end |
| credit_full | output | 1 | Credit can take no further token |
| rx_nchar | input | 1 | One-cycle pulse: a normal character arrived locally |
| rx_free | input | RXF_W | Free entries in the local receive buffer |
| tx_valid | output | 1 | Character on `tx_char` is valid |
| tx_char | output | DATA_W+2 | Parity, flag and payload of the current character |

## Verification
The choice of character is made at one clock edge from inputs and counters sampled there. It reaches `tx_char` and `tx_valid` after the following edge. `host_full` and `credit_full` settle one edge after the write or pulse that moves them. A behavioural reference in the bench applies that same edge accounting, with a two-stage queue between choice and output. The bench drives inputs on falling edges and compares every output on the next falling edge, so each result is read one half period after the edge that must produce it.

// File: rtl/ltx_pkg.sv
package ltx_pkg;

    typedef enum logic [2:0] {
        LS_ERR_RESET  = 3'd0,
        LS_ERR_WAIT   = 3'd1,
        LS_READY      = 3'd2,
        LS_STARTED    = 3'd3,
        LS_CONNECTING = 3'd4,
        LS_RUN        = 3'd5
    } link_state_e;

    typedef enum logic [1:0] {
        CC_TOKEN = 2'd0,
        CC_EOP   = 2'd1,
        CC_EEP   = 2'd2,
        CC_ESC   = 2'd3
    } ctrl_code_e;

    typedef enum logic [2:0] {
        PK_NONE,
        PK_NULL_TAIL,
        PK_TOKEN,
        PK_HOST,
        PK_NULL_HEAD
    } pick_e;

    localparam int TOKEN_CHARS = 8;

    function automatic logic is_xmit(link_state_e s);
        return (s == LS_STARTED) || (s == LS_CONNECTING) || (s == LS_RUN);
    endfunction

    function automatic logic may_token(link_state_e s);
        return (s == LS_CONNECTING) || (s == LS_RUN);
    endfunction

    function automatic logic odd_parity_bit(logic prev_x, logic flag);
        return ~(prev_x ^ flag);
    endfunction

endpackage

// File: rtl/ltx_credit.sv
module ltx_credit
    import ltx_pkg::*;
#(
    parameter int TOK_MAX = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic fct_rcvd,
    input  logic spend,
    output logic credit_avail,
    output logic credit_full
);
    localparam int CMAX = TOK_MAX * TOKEN_CHARS;
    localparam int CW   = $clog2(CMAX + 1);

    logic [CW-1:0] cnt;

    always_comb begin
        credit_full  = int'(cnt) > (CMAX - TOKEN_CHARS);
        credit_avail = (cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else begin
            cnt <= CW'(int'(cnt) - (spend ? 1 : 0)
                       + ((fct_rcvd && !credit_full) ? TOKEN_CHARS : 0));
        end
    end

    p_credit_cap_r8: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= CMAX);

    p_spend_needs_credit_r7: assert property (@(posedge clk) disable iff (rst)
        spend |-> (cnt != '0));

endmodule

// File: rtl/ltx_grant.sv
module ltx_grant
    import ltx_pkg::*;
#(
    parameter int TOK_MAX = 7,
    parameter int RXF_W   = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             fct_sent,
    input  logic             rx_nchar,
    input  logic [RXF_W-1:0] rx_free,
    output logic             fct_ok
);
    localparam int CMAX = TOK_MAX * TOKEN_CHARS;
    localparam int CW   = $clog2(CMAX + 1);

    logic [CW-1:0] gcnt;

    always_comb begin
        fct_ok = ((int'(gcnt) + TOKEN_CHARS) <= int'(rx_free))
              && ((int'(gcnt) + TOKEN_CHARS) <= CMAX);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            gcnt <= '0;
        end else begin
            gcnt <= CW'(int'(gcnt) + (fct_sent ? TOKEN_CHARS : 0)
                        - ((rx_nchar && gcnt != '0) ? 1 : 0));
        end
    end

    p_grant_cap_r9: assert property (@(posedge clk) disable iff (rst)
        int'(gcnt) <= CMAX);

endmodule

// File: rtl/ltx_select.sv
module ltx_select
    import ltx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  link_state_e       ls,
    input  logic              host_wr,
    input  logic [DATA_W:0]   host_word,
    input  logic              credit_avail,
    input  logic              fct_ok,
    output logic              host_full,
    output logic              spend,
    output logic              fct_sent,
    output logic              s1_vld,
    output logic              s1_flag,
    output logic [DATA_W-1:0] s1_payload
);
    logic              pend_v;
    logic [DATA_W:0]   pend_w;
    logic              null_half;
    pick_e             pick;
    logic              nx_flag;
    logic [DATA_W-1:0] nx_payload;

    assign host_full = pend_v;

    always_comb begin
        if (!is_xmit(ls))                            pick = PK_NONE;
        else if (null_half)                          pick = PK_NULL_TAIL;
        else if (may_token(ls) && fct_ok)            pick = PK_TOKEN;
        else if (ls == LS_RUN && pend_v && credit_avail) pick = PK_HOST;
        else                                         pick = PK_NULL_HEAD;
    end

    always_comb begin
        spend      = (pick == PK_HOST);
        fct_sent   = (pick == PK_TOKEN);
        nx_flag    = 1'b1;
        nx_payload = '0;
        unique case (pick)
            PK_HOST: begin
                if (pend_w[DATA_W]) begin
                    nx_payload[1:0] = pend_w[0] ? CC_EEP : CC_EOP;
                end else begin
                    nx_flag    = 1'b0;
                    nx_payload = pend_w[DATA_W-1:0];
                end
            end
            PK_NULL_HEAD: nx_payload[1:0] = CC_ESC;
            default:      nx_payload[1:0] = CC_TOKEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld     <= 1'b0;
            s1_flag    <= 1'b0;
            s1_payload <= '0;
            null_half  <= 1'b0;
            pend_v     <= 1'b0;
            pend_w     <= '0;
        end else begin
            s1_vld     <= (pick != PK_NONE);
            s1_flag    <= nx_flag;
            s1_payload <= nx_payload;
            null_half  <= (pick == PK_NULL_HEAD);
            if (spend) pend_v <= 1'b0;
            if (host_wr && !pend_v) begin
                pend_v <= 1'b1;
                pend_w <= host_word;
            end
        end
    end

    p_full_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (host_full && ls != LS_RUN) |=> host_full);

    p_host_only_in_run_r7: assert property (@(posedge clk) disable iff (rst)
        spend |-> (ls == LS_RUN));

    p_token_needs_room_r9: assert property (@(posedge clk) disable iff (rst)
        fct_sent |-> (fct_ok && may_token(ls)));

endmodule

// File: rtl/ltx_parity.sv
module ltx_parity
    import ltx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s1_vld,
    input  logic              s1_flag,
    input  logic [DATA_W-1:0] s1_payload,
    output logic              tx_valid,
    output logic [DATA_W+1:0] tx_char
);
    localparam logic [DATA_W+1:0] IDLE_CHAR = {1'b1, {(DATA_W+1){1'b0}}};

    logic prev_x;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_char  <= IDLE_CHAR;
            prev_x   <= 1'b0;
        end else if (s1_vld) begin
            tx_valid <= 1'b1;
            tx_char  <= {odd_parity_bit(prev_x, s1_flag), s1_flag, s1_payload};
            prev_x   <= ^s1_payload;
        end else begin
            tx_valid <= 1'b0;
            tx_char  <= IDLE_CHAR;
            prev_x   <= 1'b0;
        end
    end

    p_odd_parity_r3: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> ((tx_char[DATA_W+1] ^ tx_char[DATA_W]
                       ^ ($past(tx_valid) ? (^$past(tx_char[DATA_W-1:0])) : 1'b0)) == 1'b1));

endmodule

// File: rtl/link_char_tx.sv
module link_char_tx
    import ltx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int TOK_MAX = 7,
    parameter int RXF_W   = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        link_state,
    input  logic              host_wr,
    input  logic [DATA_W:0]   host_word,
    output logic              host_full,
    input  logic              fct_rcvd,
    output logic              credit_full,
    input  logic              rx_nchar,
    input  logic [RXF_W-1:0]  rx_free,
    output logic              tx_valid,
    output logic [DATA_W+1:0] tx_char
);
    link_state_e       ls;
    logic              xmit;
    logic              credit_avail, fct_ok, spend, fct_sent;
    logic              s1_vld, s1_flag;
    logic [DATA_W-1:0] s1_payload;

    assign ls   = link_state_e'(link_state);
    assign xmit = is_xmit(ls);

    ltx_credit #(.TOK_MAX(TOK_MAX)) u_credit (
        .clk(clk), .rst(rst), .clear(!xmit), .fct_rcvd(fct_rcvd), .spend(spend),
        .credit_avail(credit_avail), .credit_full(credit_full)
    );

    ltx_grant #(.TOK_MAX(TOK_MAX), .RXF_W(RXF_W)) u_grant (
        .clk(clk), .rst(rst), .clear(!xmit), .fct_sent(fct_sent),
        .rx_nchar(rx_nchar), .rx_free(rx_free), .fct_ok(fct_ok)
    );

    ltx_select #(.DATA_W(DATA_W)) u_select (
        .clk(clk), .rst(rst), .ls(ls), .host_wr(host_wr), .host_word(host_word),
        .credit_avail(credit_avail), .fct_ok(fct_ok), .host_full(host_full),
        .spend(spend), .fct_sent(fct_sent), .s1_vld(s1_vld), .s1_flag(s1_flag),
        .s1_payload(s1_payload)
    );

    ltx_parity #(.DATA_W(DATA_W)) u_parity (
        .clk(clk), .rst(rst), .s1_vld(s1_vld), .s1_flag(s1_flag),
        .s1_payload(s1_payload), .tx_valid(tx_valid), .tx_char(tx_char)
    );

    p_valid_state_r4: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(xmit, 2));

    p_null_pair_r6: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_char[DATA_W] && tx_char[1:0] == CC_ESC)
        |=> (!tx_valid || (tx_char[DATA_W] && tx_char[1:0] == CC_TOKEN)));

endmodule

// File: tb/sim_link_char_tx.sv
module sim_link_char_tx;
    localparam int DW   = 8;
    localparam int RXW  = 11;
    localparam logic [DW+1:0] IDLE = {1'b1, {(DW+1){1'b0}}};

    logic           clk = 1'b0;
    logic           rst;
    logic [2:0]     link_state;
    logic           host_wr, fct_rcvd, rx_nchar;
    logic [DW:0]    host_word;
    logic [RXW-1:0] rx_free;
    logic           host_full, credit_full, tx_valid;
    logic [DW+1:0]  tx_char;

    always #2 clk = ~clk;

    link_char_tx #(.DATA_W(DW), .TOK_MAX(7), .RXF_W(RXW)) u0 (
        .clk(clk), .rst(rst), .link_state(link_state), .host_wr(host_wr),
        .host_word(host_word), .host_full(host_full), .fct_rcvd(fct_rcvd),
        .credit_full(credit_full), .rx_nchar(rx_nchar), .rx_free(rx_free),
        .tx_valid(tx_valid), .tx_char(tx_char)
    );

    int n_chk = 0, n_bad = 0, n_data = 0;
    bit done = 0;

    // behavioural reference
    int          m_credit, m_grant;
    bit          m_pv, m_nh, m_s1v, m_s1f, m_prev, m_ov;
    logic [DW:0] m_pw;
    logic [DW-1:0] m_s1p;
    logic [DW+1:0] m_oc;

    always @(posedge clk) begin : model
        bit xmit, sf, sp, old_full, old_pv;
        int ls;
        if (rst) begin
            m_credit = 0; m_grant = 0; m_pv = 0; m_nh = 0; m_s1v = 0;
            m_s1f = 0; m_s1p = '0; m_prev = 0; m_ov = 0; m_oc = IDLE; m_pw = '0;
        end else begin
            ls = int'(link_state);
            if (m_s1v) begin
                m_oc = {~(m_prev ^ m_s1f), m_s1f, m_s1p};
                m_prev = ^m_s1p; m_ov = 1;
            end else begin
                m_oc = IDLE; m_prev = 0; m_ov = 0;
            end
            xmit = (ls >= 3 && ls <= 5);
            sf = 0; sp = 0;
            if (!xmit) begin
                m_s1v = 0; m_nh = 0;
            end else begin
                m_s1v = 1; m_s1f = 1; m_s1p = '0;
                if (m_nh) begin
                    m_nh = 0;
                end else if (ls >= 4 && m_grant + 8 <= int'(rx_free) && m_grant + 8 <= 56) begin
                    sf = 1;
                end else if (ls == 5 && m_pv && m_credit > 0) begin
                    sp = 1;
                    if (m_pw[DW]) m_s1p[1:0] = m_pw[0] ? 2'd2 : 2'd1;
                    else begin m_s1f = 0; m_s1p = m_pw[DW-1:0]; end
                end else begin
                    m_s1p[1:0] = 2'd3; m_nh = 1;
                end
            end
            old_full = m_credit > 48;
            if (!xmit) m_credit = 0;
            else m_credit = m_credit - (sp ? 1 : 0) + ((fct_rcvd && !old_full) ? 8 : 0);
            if (!xmit) m_grant = 0;
            else m_grant = m_grant + (sf ? 8 : 0) - ((rx_nchar && m_grant > 0) ? 1 : 0);
            old_pv = m_pv;
            if (sp) m_pv = 0;
            if (host_wr && !old_pv) begin m_pv = 1; m_pw = host_word; end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // compare against the reference every cycle, half a period after the edge
    always @(negedge clk) begin
        if (!done) begin
            chk("R4 tx_valid", int'(tx_valid), int'(m_ov));
            chk("R1 R2 R3 R5 R6 R9 tx_char", int'(tx_char), int'(m_oc));
            chk("R10 host_full", int'(host_full), int'(m_pv));
            chk("R8 credit_full", int'(credit_full), (m_credit > 48) ? 1 : 0);
            if (tx_valid && !tx_char[DW]) n_data++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_up();
    end

    initial begin
        rst = 1; link_state = 3'd0; host_wr = 0; host_word = '0;
        fct_rcvd = 0; rx_nchar = 0; rx_free = '0;
        step(3);
        // R11 reset state
        chk("R11 tx_valid", int'(tx_valid), 0);
        chk("R11 tx_char idle", int'(tx_char), int'(IDLE));
        chk("R11 host_full", int'(host_full), 0);
        chk("R11 credit_full", int'(credit_full), 0);
        rst = 0;
        link_state = 3'd2; step(5);
        chk("R4 no valid in ready", int'(tx_valid), 0);
        link_state = 3'd3; rx_free = 11'd100; step(10);
        chk("R4 valid in started", int'(tx_valid), 1);
        rx_free = 11'd20; link_state = 3'd4; step(20);
        rx_free = 11'd100; step(20);
        link_state = 3'd5; step(4);
        // word held without credit
        host_wr = 1; host_word = 9'h03A; step(1); host_wr = 0; step(8);
        chk("R10 held without credit", int'(host_full), 1);
        host_wr = 1; host_word = 9'h055; step(1); host_wr = 0;
        fct_rcvd = 1; step(1); fct_rcvd = 0; step(6);
        chk("R7 word sent once credit came", int'(host_full), 0);
        // mixed stream with markers
        for (int i = 0; i < 40; i++) begin
            if (!host_full) begin
                host_wr = 1;
                host_word = (i % 9 == 8) ? 9'h100 : (i % 13 == 12) ? 9'h101 : 9'(i * 7);
            end
            fct_rcvd = (i % 5 == 0);
            rx_nchar = (i % 2 == 0);
            step(1);
            host_wr = 0; fct_rcvd = 0; rx_nchar = 0;
        end
        step(10);
        // link drop clears counters
        link_state = 3'd0; step(4);
        chk("R8 credit cleared", int'(credit_full), 0);
        chk("R4 valid gone", int'(tx_valid), 0);
        // exactly eight characters per token
        link_state = 3'd3; step(4);
        rx_free = '0; link_state = 3'd4; step(4);
        link_state = 3'd5; step(2);
        fct_rcvd = 1; step(1); fct_rcvd = 0;
        n_data = 0;
        for (int i = 0; i < 60; i++) begin
            host_wr = !host_full; host_word = 9'(8'h80 + i);
            step(1);
        end
        host_wr = 0; step(6);
        chk("R7 one token allows eight", n_data, 8);
        chk("R10 stuck while no credit", int'(host_full), 1);
        // saturate credit
        for (int i = 0; i < 8; i++) begin
            fct_rcvd = 1; step(1); fct_rcvd = 0; step(2);
        end
        chk("R8 credit_full after seven", int'(credit_full), 1);
        // random phase
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 2) link_state = 3'(int'($urandom_range(0, 4)));
            else if (r < 12) link_state = 3'd5;
            host_wr = ($urandom_range(0, 2) != 0);
            host_word = 9'($urandom_range(0, 511));
            fct_rcvd = ($urandom_range(0, 5) == 0);
            rx_nchar = ($urandom_range(0, 2) == 0);
            if (r > 95) rx_free = 11'($urandom_range(0, 80));
            step(1);
        end
        host_wr = 0; fct_rcvd = 0; rx_nchar = 0;
        step(4);
        finish_up();
    end
endmodule